// File: doc/BRIEF.md
# Event Counting Unit with Shared or Dedicated Counters

This block counts occurrences of processor events presented as single-cycle pulses on an event vector. Software controls it through a simple register port: an event-select register chooses which events are counted, a control register holds a global run bit and a saturation bit, and a window of 32 counter slots gives read and write access to the counter values. Reads are combinational from the current address. Writes take effect at the next clock edge.

A build-time parameter picks one of two variants. In the dedicated variant, every event has its own counter and the top slot of the window is a broadcast slot: writing it loads the same value into every counter. In the shared variant, there is a single counter to save area. The selected events are ORed together, so that counter advances by at most one per cycle, and every slot of the window aliases it. A counter either stops at all-ones or wraps to zero, depending on the saturation bit.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, the control register at 0x3821 reads 0x3, the event-select register at 0x3820 reads 0, and every counter slot reads 0.
- R2: Control register bit 0 is the global run bit and bit 1 is the saturation bit. Only bits 1:0 are stored, and the other bits read 0. While the run bit is 0, no counter changes except by a software write.
- R3: The event-select register stores bit i for i in 0..16, plus bit 31, which selects all events. Other bits read 0. An event i is counted in a cycle when its input bit is high, the run bit is 1, and either select bit i or bit 31 is 1. Otherwise the counter holds its value.
- R4: In the dedicated variant, slot i at address 0x3800+i (i in 0..16) is an independent counter for event i that increments by one per counted cycle. Slots 0x3811 to 0x381E read 0, and writes to them have no effect.
- R5: In the dedicated variant, a write to 0x381F loads the written value into every counter, and a read of 0x381F returns 0.
- R6: In the shared variant, one counter increments by exactly one in any cycle in which at least one event is counted. All addresses 0x3800 to 0x381F read and write that counter.
- R7: A counted event at 0xFFFFFFFF leaves the counter at 0xFFFFFFFF when the saturation bit is 1. When the saturation bit is 0, the counter wraps to 0.
- R8: A software write to a counter in the same cycle as a counted event loads the written value, and the increment is dropped.
- R9: `reg_rdata` reflects the state at `reg_addr` in the same cycle. Addresses outside 0x3800 to 0x3821 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 16 | Register address |
| reg_we | input | 1 | Write strobe for `reg_wdata` at `reg_addr` |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| evt_i | input | 17 | Event pulses, one bit per event, sampled every cycle |

## Verification
The assertions assume that the event and register inputs are stable and known at each rising edge. They also assume that the first two edges after reset release see no register write, because the internal reset synchronizer is still holding the block in reset. The bench changes every input only on the falling edge and keeps the write strobe low through the reset window. The random phase also writes values close to all-ones, so that saturation and wrap are reached from ordinary traffic. It mixes control writes that clear the run bit among the event traffic, so that the hold rule is exercised while events are still arriving.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int unsigned SLOT_W = 5;
  localparam int unsigned SLOTS  = 32;

  typedef struct packed {
    logic sat;
    logic en;
  } pcu_mode_t;

  localparam pcu_mode_t MODE_RST = '{sat: 1'b1, en: 1'b1};

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CNT,
    SEL_MASK,
    SEL_MODE
  } pcu_sel_e;
endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
  import pcu_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned CNT_BASE = 32'h3800
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output pcu_sel_e          sel_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              wr_cnt_o,
  output logic              wr_mask_o,
  output logic              wr_mode_o
);
  localparam logic [ADDR_W-1:0] BASE     = ADDR_W'(CNT_BASE);
  localparam logic [ADDR_W-1:0] MASK_OFF = ADDR_W'(SLOTS);
  localparam logic [ADDR_W-1:0] MODE_OFF = ADDR_W'(SLOTS + 1);

  logic [ADDR_W-1:0] offs;
  logic              above;

  always_comb begin
    above = (addr_i >= BASE);
    offs  = addr_i - BASE;
    sel_o = SEL_NONE;
    if (above) begin
      if (offs < MASK_OFF)       sel_o = SEL_CNT;
      else if (offs == MASK_OFF) sel_o = SEL_MASK;
      else if (offs == MODE_OFF) sel_o = SEL_MODE;
    end
  end

  assign slot_o    = offs[SLOT_W-1:0];
  assign wr_cnt_o  = we_i && (sel_o == SEL_CNT);
  assign wr_mask_o = we_i && (sel_o == SEL_MASK);
  assign wr_mode_o = we_i && (sel_o == SEL_MODE);
endmodule

// File: rtl/pcu_cfg_regs.sv
module pcu_cfg_regs
  import pcu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_EVT = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_mask_i,
  input  logic               wr_mode_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output pcu_mode_t          mode_q,
  output logic [NUM_EVT-1:0] mask_q,
  output logic               all_q
);
  pcu_mode_t          mode_d;
  logic [NUM_EVT-1:0] mask_d;
  logic               all_d;

  always_comb begin
    mode_d = mode_q;
    mask_d = mask_q;
    all_d  = all_q;
    if (wr_mode_i) mode_d = pcu_mode_t'(wdata_i[1:0]);
    if (wr_mask_i) begin
      mask_d = wdata_i[NUM_EVT-1:0];
      all_d  = wdata_i[DATA_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      mask_q <= '0;
      all_q  <= 1'b0;
    end else begin
      if (wr_mode_i) mode_q <= mode_d;
      if (wr_mask_i) begin
        mask_q <= mask_d;
        all_q  <= all_d;
      end
    end
  end
endmodule

// File: rtl/pcu_evt_gate.sv
module pcu_evt_gate #(
  parameter int unsigned NUM_EVT = 17,
  parameter bit          SHARED  = 1'b0,
  localparam int unsigned NCNT   = SHARED ? 1 : NUM_EVT
) (
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] mask_i,
  input  logic               all_i,
  input  logic               run_i,
  output logic [NCNT-1:0]    inc_o
);
  logic [NUM_EVT-1:0] live;

  assign live = evt_i & (all_i ? {NUM_EVT{1'b1}} : mask_i);

  generate
    if (SHARED) begin : g_or
      assign inc_o = run_i && (|live);
    end else begin : g_each
      assign inc_o = run_i ? live : '0;
    end
  endgenerate
endmodule

// File: rtl/pcu_counter.sv
module pcu_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              inc_i,
  input  logic              sat_i,
  output logic [DATA_W-1:0] cnt_q
);
  logic [DATA_W-1:0] cnt_d;
  logic              upd;
  logic              at_max;

  always_comb begin
    at_max = &cnt_q;
    upd    = load_i || inc_i;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (inc_i) begin
      if (at_max) cnt_d = sat_i ? cnt_q : '0;
      else        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import pcu_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned NUM_EVT  = 17,
  parameter bit          SHARED   = 1'b0,
  parameter int unsigned CNT_BASE = 32'h3800
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_EVT-1:0] evt_i
);
  localparam int unsigned NCNT      = SHARED ? 1 : NUM_EVT;
  localparam logic [SLOT_W-1:0] BCAST = SLOT_W'(SLOTS - 1);

  logic [1:0]         rst_sync;
  logic               rst_sync_n;
  pcu_sel_e           sel;
  logic [SLOT_W-1:0]  slot;
  logic               wr_cnt, wr_mask, wr_mode;
  pcu_mode_t          mode_q;
  logic [NUM_EVT-1:0] mask_q;
  logic               all_q;
  logic [NCNT-1:0]    inc;
  logic [NCNT-1:0]    load;
  logic [DATA_W-1:0]  cnt_val [NCNT];
  logic [DATA_W-1:0]  mask_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  pcu_decode #(.ADDR_W(ADDR_W), .CNT_BASE(CNT_BASE)) u_dec (
    .addr_i(reg_addr), .we_i(reg_we), .sel_o(sel), .slot_o(slot),
    .wr_cnt_o(wr_cnt), .wr_mask_o(wr_mask), .wr_mode_o(wr_mode)
  );

  pcu_cfg_regs #(.DATA_W(DATA_W), .NUM_EVT(NUM_EVT)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .wr_mask_i(wr_mask), .wr_mode_i(wr_mode),
    .wdata_i(reg_wdata), .mode_q(mode_q), .mask_q(mask_q), .all_q(all_q)
  );

  pcu_evt_gate #(.NUM_EVT(NUM_EVT), .SHARED(SHARED)) u_gate (
    .evt_i(evt_i), .mask_i(mask_q), .all_i(all_q), .run_i(mode_q.en), .inc_o(inc)
  );

  generate
    for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
      if (SHARED) begin : g_ld_sh
        assign load[gi] = wr_cnt;
      end else begin : g_ld_ded
        assign load[gi] = wr_cnt && ((slot == SLOT_W'(gi)) || (slot == BCAST));
      end
      pcu_counter #(.DATA_W(DATA_W)) u_ctr (
        .clk(clk), .rst_n(rst_sync_n), .load_i(load[gi]), .load_val_i(reg_wdata),
        .inc_i(inc[gi]), .sat_i(mode_q.sat), .cnt_q(cnt_val[gi])
      );
    end
  endgenerate

  always_comb begin
    mask_word                = '0;
    mask_word[NUM_EVT-1:0]   = mask_q;
    mask_word[DATA_W-1]      = all_q;
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_CNT: begin
        if (SHARED) begin
          reg_rdata = cnt_val[0];
        end else begin
          for (int i = 0; i < NCNT; i++) begin
            if (slot == SLOT_W'(i)) reg_rdata = cnt_val[i];
          end
        end
      end
      SEL_MASK: reg_rdata = mask_word;
      SEL_MODE: reg_rdata = DATA_W'(mode_q);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pcu_chk.sv
module pcu_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned CNT_BASE = 32'h3800
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [DATA_W-1:0] cnt0,
  input logic              mode_en,
  input logic              mode_sat
);
  localparam logic [ADDR_W-1:0] LO     = ADDR_W'(CNT_BASE);
  localparam logic [ADDR_W-1:0] CNT_HI = ADDR_W'(CNT_BASE + 31);
  localparam logic [ADDR_W-1:0] TOP    = ADDR_W'(CNT_BASE + 33);

  logic in_cnt, mapped, wr_any_cnt;
  assign in_cnt     = (reg_addr >= LO) && (reg_addr <= CNT_HI);
  assign mapped     = (reg_addr >= LO) && (reg_addr <= TOP);
  assign wr_any_cnt = reg_we && in_cnt;

  // R2
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_en && !wr_any_cnt) |=> $stable(cnt0));

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any_cnt |=> ((cnt0 == $past(cnt0)) || (cnt0 == $past(cnt0) + 1'b1)));

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sat && (&cnt0) && !wr_any_cnt) |=> (&cnt0));

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == LO)) |=> (cnt0 == $past(reg_wdata)));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (reg_rdata == '0));
endmodule

bind perf_counter_unit pcu_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_BASE(CNT_BASE)
) u_pcu_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt0(cnt_val[0]),
  .mode_en(mode_q.en), .mode_sat(mode_q.sat)
);

// File: tb/perf_counter_unit_bench.sv
module perf_counter_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reg_addr = 16'h0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = 32'h0;
  logic [NE-1:0] evt = '0;
  logic [31:0] rdata_d, rdata_s;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference state
  logic [31:0] m_cnt [NE];
  logic [31:0] m_sh;
  logic [1:0]  m_mode;
  logic [31:0] m_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_counter_unit #(.SHARED(1'b0)) u_perf_counter_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_d), .evt_i(evt));

  perf_counter_unit #(.SHARED(1'b1)) u_perf_counter_unit_sh (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_s), .evt_i(evt));

  function automatic bit in_cnt(input logic [15:0] a);
    return (a >= 16'h3800) && (a <= 16'h381F);
  endfunction

  function automatic logic [31:0] m_read(input bit sh, input logic [15:0] a);
    if (in_cnt(a)) begin
      if (sh) return m_sh;
      if (int'(a - 16'h3800) < NE) return m_cnt[int'(a - 16'h3800)];
      return 32'h0;
    end
    if (a == 16'h3820) return m_mask;
    if (a == 16'h3821) return {30'h0, m_mode};
    return 32'h0;
  endfunction

  function automatic logic [31:0] bump(input logic [31:0] v);
    if (v == 32'hFFFF_FFFF) return m_mode[1] ? v : 32'h0;
    return v + 32'h1;
  endfunction

  function automatic string req_of(input bit sh, input logic [15:0] a, input string t);
    if (t != "") return t;
    if (in_cnt(a)) return sh ? "R6" : "R4";
    if (a == 16'h3820) return "R3";
    if (a == 16'h3821) return "R2";
    return "R9";
  endfunction

  task automatic check(input string req, input string inst, input logic [31:0] got,
                       input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s addr=%h got=%h exp=%h", req, inst, reg_addr, got, exp);
    end
  endtask

  task automatic m_update();
    logic [NE-1:0] eff;
    logic [4:0] slot;
    eff  = m_mask[31] ? {NE{1'b1}} : m_mask[NE-1:0];
    slot = reg_addr[4:0];
    for (int i = 0; i < NE; i++) begin
      if (reg_we && in_cnt(reg_addr) && (int'(slot) == i || slot == 5'd31))
        m_cnt[i] = reg_wdata;
      else if (m_mode[0] && eff[i] && evt[i])
        m_cnt[i] = bump(m_cnt[i]);
    end
    if (reg_we && in_cnt(reg_addr)) m_sh = reg_wdata;
    else if (m_mode[0] && |(eff & evt)) m_sh = bump(m_sh);
    if (reg_we && reg_addr == 16'h3820) m_mask = reg_wdata & 32'h8001_FFFF;
    if (reg_we && reg_addr == 16'h3821) m_mode = reg_wdata[1:0];
  endtask

  task automatic step(input logic [15:0] a, input logic we, input logic [31:0] wd,
                      input logic [NE-1:0] ev, input string tag);
    @(negedge clk);
    reg_addr  = a;
    reg_we    = we;
    reg_wdata = wd;
    evt       = ev;
    #1;
    check(req_of(1'b0, a, tag), "dedicated", rdata_d, m_read(1'b0, a));
    check(req_of(1'b1, a, tag), "shared", rdata_s, m_read(1'b1, a));
    m_update();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired got=running exp=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NE; i++) m_cnt[i] = 32'h0;
    m_sh = 32'h0; m_mode = 2'b11; m_mask = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values
    step(16'h3821, 1'b0, 32'h0, '0, "R1");
    step(16'h3820, 1'b0, 32'h0, '0, "R1");
    step(16'h3800, 1'b0, 32'h0, '0, "R1");
    step(16'h3810, 1'b0, 32'h0, '0, "R1");

    // R3 select cycle event only, then drive events
    step(16'h3820, 1'b1, 32'hFFFF_FFFF, '0, "R3");
    step(16'h3820, 1'b1, 32'h0000_0005, '0, "R3");
    step(16'h3820, 1'b0, 32'h0, 17'h1FFFF, "R3");
    step(16'h3800, 1'b0, 32'h0, 17'h00006, "R3");
    step(16'h3802, 1'b0, 32'h0, 17'h00005, "R3");
    step(16'h3801, 1'b0, 32'h0, '0, "R3");
    step(16'h3800, 1'b0, 32'h0, '0, "R4");

    // R2 run bit off freezes counting
    step(16'h3821, 1'b1, 32'hFFFF_FFF2, 17'h1FFFF, "R2");
    step(16'h3821, 1'b0, 32'h0, 17'h1FFFF, "R2");
    step(16'h3800, 1'b0, 32'h0, 17'h1FFFF, "R2");
    step(16'h3800, 1'b0, 32'h0, '0, "R2");
    step(16'h3821, 1'b1, 32'h3, '0, "R2");

    // R5 broadcast write
    step(16'h381F, 1'b1, 32'h0000_0055, '0, "R5");
    step(16'h381F, 1'b0, 32'h0, '0, "R5");
    step(16'h3805, 1'b0, 32'h0, '0, "R5");
    step(16'h3810, 1'b0, 32'h0, '0, "R5");

    // R4 gap slots, R9 unmapped
    step(16'h3815, 1'b1, 32'h1234_5678, '0, "R4");
    step(16'h3815, 1'b0, 32'h0, '0, "R4");
    step(16'h3805, 1'b0, 32'h0, '0, "R4");
    step(16'h1234, 1'b1, 32'hDEAD_BEEF, '0, "R9");
    step(16'h3822, 1'b0, 32'h0, '0, "R9");
    step(16'h37FF, 1'b0, 32'h0, '0, "R9");

    // R7 saturation then wrap on event 3 via ALL selector
    step(16'h3820, 1'b1, 32'h8000_0000, '0, "R7");
    step(16'h3803, 1'b1, 32'hFFFF_FFFE, '0, "R7");
    step(16'h3803, 1'b0, 32'h0, 17'h00008, "R7");
    step(16'h3803, 1'b0, 32'h0, 17'h00008, "R7");
    step(16'h3803, 1'b0, 32'h0, 17'h00008, "R7");
    step(16'h3821, 1'b1, 32'h1, '0, "R7");
    step(16'h3803, 1'b1, 32'hFFFF_FFFF, '0, "R7");
    step(16'h3803, 1'b0, 32'h0, 17'h00008, "R7");
    step(16'h3803, 1'b0, 32'h0, '0, "R7");

    // R8 write beats increment
    step(16'h3800, 1'b1, 32'h0000_0010, 17'h1FFFF, "R8");
    step(16'h3800, 1'b0, 32'h0, '0, "R8");
    step(16'h3801, 1'b0, 32'h0, '0, "R6");

    // random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [15:0] a;
      logic        w;
      logic [31:0] d;
      int r;
      r = $urandom_range(0, 39);
      if (r < 34) a = 16'h3800 + 16'(r);
      else        a = 16'($urandom);
      w = ($urandom_range(0, 7) == 0);
      d = $urandom;
      if ($urandom_range(0, 3) == 0) d = 32'hFFFF_FFF0 | 32'($urandom_range(0, 15));
      if (a == 16'h3821 && $urandom_range(0, 3) != 0) d = 32'h3 | d[1:0];
      step(a, w, d, NE'($urandom), "");
    end

    finish_run();
  end
endmodule